// File: doc/BRIEF.md
# Condition field mask logic unit

This execution block lets a scalar core use 4-bit condition fields as predicate material without a long chain of single-bit logic operations. It owns a 32-bit condition register made of eight 4-bit fields. Each field holds, from its most significant bit down, a less-than flag, a greater-than flag, an equal flag and an overflow flag. A 4-bit mask selects which of those four bits take part in an operation. A 4-bit set/clear map either inverts them or supplies constants.

Three operation families are provided. A reduction collapses the masked bits of one field to a single 0/1 integer result, using either AND or OR. An integer-to-field update drives the masked bits of one field from bit 0 of an integer operand, or from the map alone when the integer register index is zero. A field-to-field combine merges the masked bits of a source field, optionally inverted, into a destination field by copy, AND, OR or XOR. The reduction result is combinational from the current register contents. Register updates commit on the next rising clock edge.

Top module: `cfmask_unit`

## Requirements
- R1: A synchronous reset clears the whole condition register to zero, and the cleared value is visible on `crImage` after the reset edge.
- R2: Field k occupies `crImage[31-4k : 28-4k]`, so field 0 is the most significant nibble. Within a field, bit 3 is lt, bit 2 is gt, bit 1 is eq and bit 0 is ov. Mask bit i and map bit i refer to field bit i.
- R3: With `opSel`=0 (reduce) and `modeOr`=0, the result is the AND of the source field bits whose mask bit is set. An empty mask yields 1.
- R4: With `opSel`=0 and `modeOr`=1, the result is the OR of the masked source field bits. An empty mask yields 0.
- R5: A valid reduction raises `intWe`, places the 0/1 value in `intResult[0]` with bits 63..1 zero, and leaves the condition register unchanged. For every other operation, `intWe` is 0 and `intResult` is 0.
- R6: With `opSel`=1 (integer-to-field) and a nonzero `srcRegIdx`, each destination bit whose mask bit is set becomes `intOperand[0]` XOR its map bit. Bits whose mask bit is clear keep their old value.
- R7: With `opSel`=1 and `srcRegIdx`=0, `intOperand` is ignored and each masked destination bit takes its map bit.
- R8: With `opSel`=2 (field-to-field), each masked destination bit becomes the old destination bit combined with (source bit XOR map bit). `logicFn` selects the combine: 0 copy, 1 AND, 2 OR, 3 XOR. Unmasked destination bits are kept.
- R9: A register write changes only the field selected by `dstField`. All other fields keep their values.
- R10: While `opValid` is 0, the condition register holds its value and `intWe` stays 0.
- R11: `opSel`=3 is reserved. It writes nothing and raises no integer result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation present this cycle |
| opSel | input | 2 | 0 reduce, 1 integer-to-field, 2 field-to-field, 3 reserved |
| mask | input | 4 | Selects the participating field bits |
| setMap | input | 4 | Per-bit inversion or constant map |
| modeOr | input | 1 | Reduction kind: 0 AND, 1 OR |
| logicFn | input | 2 | Field-to-field combine: 0 copy, 1 AND, 2 OR, 3 XOR |
| srcField | input | 3 | Source field index |
| dstField | input | 3 | Destination field index |
| srcRegIdx | input | 5 | Integer source register index; zero selects immediate mode |
| intOperand | input | 64 | Integer source register value |
| intResult | output | 64 | Zero-extended reduction result |
| intWe | output | 1 | Integer result write enable |
| crImage | output | 32 | Current condition register contents |

## Verification
The bench builds the unit with its default parameters: four-bit fields, eight fields, a 64-bit integer path and 5-bit register indices. These values make every field index from 0 to 7 reachable. They also make the zero-extension of the full 64-bit result observable, and they cover the zero/nonzero split of the register index that selects immediate mode. A reference model in the bench tracks the whole register through a fixed vector table and a long random run. Empty and full masks, every combine function, overlapping source and destination fields, the reserved opcode and idle cycles with live inputs are therefore all compared against the model.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  typedef enum logic [1:0] {
    OP_REDUCE = 2'd0,
    OP_INT2F  = 2'd1,
    OP_F2F    = 2'd2,
    OP_RSV    = 2'd3
  } cfmOp_e;

  typedef enum logic [1:0] {
    FN_COPY = 2'd0,
    FN_AND  = 2'd1,
    FN_OR   = 2'd2,
    FN_XOR  = 2'd3
  } cfmFn_e;

  typedef struct packed {
    logic reduceEn;
    logic intUpdEn;
    logic fieldUpdEn;
    logic useImm;
    logic crWe;
  } cfmStrobe_t;

endpackage

// File: rtl/cfm_ctrl.sv
module cfm_ctrl
  import cfm_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 opValid,
  input  logic [1:0]           opSel,
  input  logic [REG_IDX_W-1:0] srcRegIdx,
  output cfmStrobe_t           strobe
);

  cfmOp_e opKind;

  always_comb begin
    opKind            = cfmOp_e'(opSel);
    strobe            = '0;
    strobe.reduceEn   = opValid && (opKind == OP_REDUCE);
    strobe.intUpdEn   = opValid && (opKind == OP_INT2F);
    strobe.fieldUpdEn = opValid && (opKind == OP_F2F);
    strobe.useImm     = (srcRegIdx == '0);
    strobe.crWe       = strobe.intUpdEn || strobe.fieldUpdEn;
  end

  // R5
  one_family_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.reduceEn, strobe.intUpdEn, strobe.fieldUpdEn}));

  // R11
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == 2'd3) |-> !(strobe.crWe || strobe.reduceEn));

endmodule

// File: rtl/cfm_datapath.sv
module cfm_datapath
  import cfm_pkg::*;
#(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  parameter int INT_W      = 64,
  localparam int FIDX_W    = $clog2(NUM_FIELDS),
  localparam int CR_W      = FIELD_W * NUM_FIELDS
) (
  input  logic               clk,
  input  logic               rst,
  input  cfmStrobe_t         strobe,
  input  logic [FIELD_W-1:0] mask,
  input  logic [FIELD_W-1:0] setMap,
  input  logic               modeOr,
  input  logic [1:0]         logicFn,
  input  logic [FIDX_W-1:0]  srcField,
  input  logic [FIDX_W-1:0]  dstField,
  input  logic [INT_W-1:0]   intOperand,
  output logic [INT_W-1:0]   intResult,
  output logic               intWe,
  output logic [CR_W-1:0]    crImage
);

  logic [CR_W-1:0]    crReg;
  logic [CR_W-1:0]    crNext;
  logic [FIELD_W-1:0] fieldArr [NUM_FIELDS];
  logic [FIELD_W-1:0] srcVal;
  logic [FIELD_W-1:0] dstVal;
  logic [FIELD_W-1:0] srcAdj;
  logic [FIELD_W-1:0] updVal;
  logic [FIELD_W-1:0] newField;
  logic               andRed;
  logic               orRed;
  logic               redBit;
  logic               intBit;

  // Split the register into fields, field 0 at the top nibble.
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_unpack
    assign fieldArr[f] = crReg[CR_W-1-f*FIELD_W -: FIELD_W];
  end

  assign srcVal = fieldArr[srcField];
  assign dstVal = fieldArr[dstField];

  // Masked reduction: unmasked bits are neutral for each operator.
  assign andRed = &(srcVal | ~mask);
  assign orRed  = |(srcVal & mask);
  assign redBit = modeOr ? orRed : andRed;

  assign intResult = strobe.reduceEn ? {{(INT_W-1){1'b0}}, redBit} : '0;
  assign intWe     = strobe.reduceEn;

  // Integer-to-field source bit; immediate mode contributes only the map.
  assign intBit = strobe.useImm ? 1'b0 : intOperand[0];
  assign srcAdj = srcVal ^ setMap;

  always_comb begin
    updVal = dstVal;
    if (strobe.intUpdEn) begin
      updVal = {FIELD_W{intBit}} ^ setMap;
    end else if (strobe.fieldUpdEn) begin
      unique case (cfmFn_e'(logicFn))
        FN_COPY: updVal = srcAdj;
        FN_AND:  updVal = dstVal & srcAdj;
        FN_OR:   updVal = dstVal | srcAdj;
        FN_XOR:  updVal = dstVal ^ srcAdj;
        default: updVal = dstVal;
      endcase
    end
  end

  assign newField = (updVal & mask) | (dstVal & ~mask);

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_pack
    assign crNext[CR_W-1-f*FIELD_W -: FIELD_W] =
      (dstField == FIDX_W'(f)) ? newField : fieldArr[f];

    // R9
    other_field_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (dstField != FIDX_W'(f)) |=>
        (crReg[CR_W-1-f*FIELD_W -: FIELD_W] == $past(fieldArr[f])));
  end

  always_ff @(posedge clk) begin
    if (rst)             crReg <= '0;
    else if (strobe.crWe) crReg <= crNext;
  end

  assign crImage = crReg;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (crReg == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.crWe |=> (crReg == $past(crReg)));

  // R6
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.crWe |=>
      ((fieldArr[$past(dstField)] & ~$past(mask)) == ($past(dstVal) & ~$past(mask))));

  // R3
  and_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.reduceEn && !modeOr && mask == '0) |-> (intResult == INT_W'(1)));

  // R4
  or_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.reduceEn && modeOr && mask == '0) |-> (intResult == '0));

  // R5
  zext_chk: assert property (@(posedge clk) disable iff (rst)
    intWe |-> (intResult[INT_W-1:1] == '0));

endmodule

// File: rtl/cfmask_unit.sv
module cfmask_unit
  import cfm_pkg::*;
#(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  parameter int INT_W      = 64,
  parameter int REG_IDX_W  = 5,
  localparam int FIDX_W    = $clog2(NUM_FIELDS),
  localparam int CR_W      = FIELD_W * NUM_FIELDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 opValid,
  input  logic [1:0]           opSel,
  input  logic [FIELD_W-1:0]   mask,
  input  logic [FIELD_W-1:0]   setMap,
  input  logic                 modeOr,
  input  logic [1:0]           logicFn,
  input  logic [FIDX_W-1:0]    srcField,
  input  logic [FIDX_W-1:0]    dstField,
  input  logic [REG_IDX_W-1:0] srcRegIdx,
  input  logic [INT_W-1:0]     intOperand,
  output logic [INT_W-1:0]     intResult,
  output logic                 intWe,
  output logic [CR_W-1:0]      crImage
);

  cfmStrobe_t strobe;

  cfm_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opValid   (opValid),
    .opSel     (opSel),
    .srcRegIdx (srcRegIdx),
    .strobe    (strobe)
  );

  cfm_datapath #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS),
    .INT_W      (INT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .mask       (mask),
    .setMap     (setMap),
    .modeOr     (modeOr),
    .logicFn    (logicFn),
    .srcField   (srcField),
    .dstField   (dstField),
    .intOperand (intOperand),
    .intResult  (intResult),
    .intWe      (intWe),
    .crImage    (crImage)
  );

endmodule

// File: tb/sim_cfmask_unit.sv
module sim_cfmask_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // Packing: op[24:23] mask[22:19] map[18:15] mode[14] fn[13:12]
  //          src[11:9] dst[8:6] ridx[5:1] opb[0]
  localparam logic [24:0] VEC [NVEC] = '{
    {2'd1, 4'hF, 4'hA, 1'b0, 2'd0, 3'd0, 3'd0, 5'd0, 1'b0},
    {2'd1, 4'h6, 4'h2, 1'b0, 2'd0, 3'd0, 3'd3, 5'd5, 1'b1},
    {2'd0, 4'hA, 4'h0, 1'b0, 2'd0, 3'd0, 3'd0, 5'd0, 1'b0},
    {2'd0, 4'hC, 4'h0, 1'b0, 2'd0, 3'd0, 3'd0, 5'd0, 1'b0},
    {2'd0, 4'h0, 4'h0, 1'b0, 2'd0, 3'd0, 3'd0, 5'd0, 1'b0},
    {2'd0, 4'h0, 4'h0, 1'b1, 2'd0, 3'd0, 3'd0, 5'd0, 1'b0},
    {2'd0, 4'h5, 4'h0, 1'b1, 2'd0, 3'd0, 3'd0, 5'd0, 1'b0},
    {2'd2, 4'hF, 4'h1, 1'b0, 2'd3, 3'd0, 3'd3, 5'd0, 1'b0},
    {2'd2, 4'hB, 4'h0, 1'b0, 2'd0, 3'd3, 3'd7, 5'd0, 1'b0},
    {2'd2, 4'hF, 4'h4, 1'b0, 2'd1, 3'd0, 3'd7, 5'd0, 1'b0},
    {2'd2, 4'h3, 4'hF, 1'b0, 2'd2, 3'd3, 3'd3, 5'd0, 1'b0},
    {2'd3, 4'hF, 4'hF, 1'b1, 2'd3, 3'd0, 3'd0, 5'd9, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [1:0]  opSel;
  logic [3:0]  mask;
  logic [3:0]  setMap;
  logic        modeOr;
  logic [1:0]  logicFn;
  logic [2:0]  srcField;
  logic [2:0]  dstField;
  logic [4:0]  srcRegIdx;
  logic [63:0] intOperand;
  logic [63:0] intResult;
  logic        intWe;
  logic [31:0] crImage;

  logic [31:0] mCr;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfmask_unit u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opSel(opSel), .mask(mask),
    .setMap(setMap), .modeOr(modeOr), .logicFn(logicFn), .srcField(srcField),
    .dstField(dstField), .srcRegIdx(srcRegIdx), .intOperand(intOperand),
    .intResult(intResult), .intWe(intWe), .crImage(crImage)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fld(input logic [31:0] cr, input int i);
    return cr[31-4*i -: 4];
  endfunction

  function automatic string opTag(input logic [1:0] op, input logic md, input logic [4:0] ridx);
    case (op)
      2'd0:    return md ? "R4" : "R3";
      2'd1:    return (ridx == 0) ? "R7" : "R6";
      2'd2:    return "R8";
      default: return "R11";
    endcase
  endfunction

  // One operation: drive at negedge, check combinational result, check register next negedge.
  task automatic applyOp(input logic [1:0] op, input logic [3:0] mk, input logic [3:0] mp,
                         input logic md, input logic [1:0] fn, input logic [2:0] sf,
                         input logic [2:0] df, input logic [4:0] ridx, input logic [63:0] opnd);
    logic [3:0] s, d, upd, nf;
    logic b;
    string tag;
    tag = opTag(op, md, ridx);
    @(negedge clk);
    opValid = 1'b1; opSel = op; mask = mk; setMap = mp; modeOr = md; logicFn = fn;
    srcField = sf; dstField = df; srcRegIdx = ridx; intOperand = opnd;
    #1;
    s = fld(mCr, int'(sf));
    d = fld(mCr, int'(df));
    if (op == 2'd0) begin
      b = md ? |(s & mk) : &(s | ~mk);
      check({tag, " result"}, intResult, {63'b0, b});
      check("R5 write enable", {63'b0, intWe}, 64'd1);
    end else begin
      check({tag, " R5 no result"}, {intResult[62:0], intWe}, 64'd0);
    end
    upd = d;
    if (op == 2'd1) begin
      b = (ridx == 0) ? 1'b0 : opnd[0];
      upd = {4{b}} ^ mp;
    end else if (op == 2'd2) begin
      case (fn)
        2'd0: upd = s ^ mp;
        2'd1: upd = d & (s ^ mp);
        2'd2: upd = d | (s ^ mp);
        default: upd = d ^ (s ^ mp);
      endcase
    end
    if (op == 2'd1 || op == 2'd2) begin
      nf = (upd & mk) | (d & ~mk);
      mCr[31-4*int'(df) -: 4] = nf;
    end
    @(negedge clk);
    opValid = 1'b0;
    check({tag, " R9 register"}, {32'b0, crImage}, {32'b0, mCr});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mCr = '0;
    check("R1 reset clears", {32'b0, crImage}, 64'd0);
  endtask

  initial begin
    rst = 1'b1; opValid = 1'b0; opSel = '0; mask = '0; setMap = '0; modeOr = 1'b0;
    logicFn = '0; srcField = '0; dstField = '0; srcRegIdx = '0; intOperand = '0;
    mCr = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", {32'b0, crImage}, 64'd0);

    // R2: field placement at both ends of the register
    applyOp(2'd1, 4'hF, 4'h8, 1'b0, 2'd0, 3'd0, 3'd0, 5'd0, 64'd0);
    check("R2 field0 lt at bit31", {32'b0, crImage}, 64'h8000_0000);
    applyOp(2'd1, 4'hF, 4'h1, 1'b0, 2'd0, 3'd0, 3'd7, 5'd0, 64'd0);
    check("R2 field7 ov at bit0", {32'b0, crImage}, 64'h8000_0001);
    doReset();

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      applyOp(VEC[i][24:23], VEC[i][22:19], VEC[i][18:15], VEC[i][14], VEC[i][13:12],
              VEC[i][11:9], VEC[i][8:6], VEC[i][5:1],
              {$urandom(), $urandom()} & ~64'd1 | {63'b0, VEC[i][0]});
    end

    // R7: immediate mode ignores operand bit 0 = 1
    applyOp(2'd1, 4'h9, 4'h1, 1'b0, 2'd0, 3'd0, 3'd4, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 operand ignored", {60'b0, crImage[15:12]}, {60'b0, 4'b0001});

    // R10: idle cycle with live write inputs
    @(negedge clk);
    opValid = 1'b0; opSel = 2'd1; mask = 4'hF; setMap = 4'hF; dstField = 3'd2; srcRegIdx = 5'd0;
    #1;
    check("R10 no int write", {63'b0, intWe}, 64'd0);
    @(negedge clk);
    check("R10 register held", {32'b0, crImage}, {32'b0, mCr});

    // Random run
    for (int i = 0; i < 600; i++) begin
      applyOp(2'($urandom()), 4'($urandom()), 4'($urandom()), 1'($urandom()),
              2'($urandom()), 3'($urandom()), 3'($urandom()),
              (($urandom() % 4) == 0) ? 5'd0 : 5'($urandom()),
              {$urandom(), $urandom()});
    end

    doReset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule